// File: doc/BRIEF.md
# SD Card SPI-Mode Block Write Engine

This engine carries the data phase of a card write over an SPI link once a write command has already been accepted by the card. It takes a block count, a block size in bytes, and a flag that picks single-block or multi-block framing, then starts on a one-cycle `start` pulse. Payload bytes arrive on a valid/ready byte stream. For each block the engine shifts out an idle byte and the start token, then the payload, then a 16-bit checksum. It then reads back the card's data-response token and polls the line until the card stops signalling busy. A multi-block run ends with a stop token and one last busy wait.

The SPI side runs in mode 0. The clock rests low, MOSI changes while the clock is low, and MISO is sampled on the rising edge. The clock runs at the system clock divided by `2*HALF`. Whenever the engine reads, it drives 0xFF on MOSI. If the payload stream has no byte ready, the SPI clock stops between bytes. When the run ends, a one-cycle `done` pulse appears and `result` holds the outcome: ok (0), rejected (1) or timeout (2).

The controller has twelve states, each named for the byte it moves:
- `S_IDLE` waits for `start`.
- `S_FILL` sends the idle byte and `S_TOKEN` sends the start token.
- `S_DATA` streams the payload.
- `S_CRC_HI` and `S_CRC_LO` send the checksum.
- `S_RESP` searches for the response token.
- `S_BUSY` waits out the card's busy period after a block.
- `S_STOP_FILL`, `S_STOP_TOK` and `S_STOP_BUSY` send the closing stop sequence.
- `S_DONE` reports the outcome.

Each send state moves on once its byte has finished shifting, with these transitions:
- IDLE→FILL on start, or IDLE→DONE when the count is zero.
- FILL→TOKEN.
- TOKEN→DATA, or TOKEN→CRC_HI when the size is zero.
- DATA→CRC_HI after the last payload byte.
- CRC_HI→CRC_LO→RESP.
- RESP→BUSY on an accepted token, or RESP→DONE on a rejection.
- BUSY→FILL for the next block, BUSY→STOP_FILL after the last block of a multi-block run, and BUSY→DONE after the last single-block block or on timeout.
- STOP_FILL→STOP_TOK→STOP_BUSY→DONE.
- DONE→IDLE.

Top module: `sd_blkwr_engine`

## Requirements
- R1: Every block opens with the byte 0xFF and then a start token. The token is 0xFE when `multi` is 0 and 0xFC when `multi` is 1.
- R2: Payload bytes are sent in arrival order, one per valid/ready handshake. `in_ready` is high only while the engine waits for a payload byte. While `in_valid` stays low in that wait, the SPI clock makes no edges.
- R3: Two checksum bytes follow each payload, high byte first. The checksum is CRC-16 with polynomial 0x1021 and initial value 0x0000, computed MSB-first over that block's payload.
- R4: After the checksum the engine reads up to RESP_TRIES (8) bytes with MOSI held at 0xFF. The response is the first byte with bit 4 = 0 and bit 0 = 1. If no byte matches, the last byte read is taken as the response.
- R5: A response whose low five bits are not 0x05 ends the run with `result` = 1 (rejected). No further bytes are sent, including any stop token.
- R6: After an accepted response the engine polls bytes. It ignores the first polled byte whatever its value, and the busy wait ends at the first later byte equal to 0xFF. The next block then begins.
- R7: If BUSY_POLLS (64) polls pass without the wait ending, either after a block or after the stop token, the run ends with `result` = 2 (timeout).
- R8: When every block of a multi-block run has been accepted, the engine sends 0xFF and then 0xFD, performs the busy wait of R6, and ends with `result` = 0.
- R9: `done` is high for exactly one cycle. `busy` is high from the cycle after `start` through the `done` cycle, and `result` keeps its value after `done`.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: A block count of zero ends the run with `result` = 0 and sends no SPI byte.
- R12: After reset, and while idle, SCLK is low, MOSI is high, and `busy`, `done` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that launches a run |
| multi | input | 1 | 1 = multi-block framing, 0 = single-block framing |
| blk_count | input | CNT_W | Number of blocks to send |
| blk_size | input | SIZE_W | Payload bytes per block |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Engine takes `in_data` this cycle if `in_valid` is high |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 ok, 1 rejected, 2 timeout |

## Verification
Only the end result has a fixed place in time: `done` rises one cycle after the last polled or response byte finishes shifting. The bench waits for that pulse, samples on falling clock edges, and checks on the next falling edge that `done` and `busy` are both low and `result` is unchanged. Byte-level behaviour is checked as a sequence, not against a cycle count. A card model records every MOSI byte on rising SCLK edges and serves a scripted MISO byte stream, and the bench compares the recorded sequence and its length with one it builds from the requirements. The stall check counts SCLK rising edges over a 100-cycle window in which `in_ready` is high and `in_valid` is low, and expects none.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FILL,
        S_TOKEN,
        S_DATA,
        S_CRC_HI,
        S_CRC_LO,
        S_RESP,
        S_BUSY,
        S_STOP_FILL,
        S_STOP_TOK,
        S_STOP_BUSY,
        S_DONE
    } sdw_state_t;

    typedef enum logic [1:0] {
        SDW_OK      = 2'd0,
        SDW_REJECT  = 2'd1,
        SDW_TIMEOUT = 2'd2
    } sdw_result_t;

    localparam logic [7:0] SDW_IDLE_BYTE = 8'hFF;
    localparam logic [7:0] SDW_TOK_ONE   = 8'hFE;
    localparam logic [7:0] SDW_TOK_MULTI = 8'hFC;
    localparam logic [7:0] SDW_TOK_STOP  = 8'hFD;
    localparam logic [4:0] SDW_ACCEPTED  = 5'h05;

endpackage

// File: rtl/sdw_spi_shift.sv
// Mode-0 byte shifter: clock rests low, MOSI set while low, MISO taken on the rise.
module sdw_spi_shift #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx,
    output logic       done,
    output logic       active
);
    localparam int CW = $clog2(HALF + 1);

    logic [CW-1:0] cnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            bitn   <= '0;
            sh     <= '0;
            rx     <= '0;
            sclk   <= 1'b0;
            mosi   <= 1'b1;
            done   <= 1'b0;
            active <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sh     <= tx;
                    mosi   <= tx[7];
                    bitn   <= '0;
                    cnt    <= '0;
                    sclk   <= 1'b0;
                end
            end else if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rx   <= {rx[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bitn == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        mosi   <= 1'b1;
                    end else begin
                        bitn <= bitn + 3'd1;
                        sh   <= {sh[6:0], 1'b0};
                        mosi <= sh[6];
                    end
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assert_sclk_rest_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sclk);

    assert_done_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active && !sclk);

endmodule

// File: rtl/sdw_crc16.sv
// CRC-16, polynomial 0x1021, seeded with zero, fed MSB-first one byte at a time.
module sdw_crc16 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    function automatic logic [15:0] fold_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
        end
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= fold_byte(crc, din);
        end
    end

    assert_crc_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> crc == 16'h0000);

endmodule

// File: rtl/sd_blkwr_engine.sv
module sd_blkwr_engine
    import sdw_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int SIZE_W     = 10,
    parameter int HALF       = 2,
    parameter int RESP_TRIES = 8,
    parameter int BUSY_POLLS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              multi,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    localparam int RESP_W = $clog2(RESP_TRIES + 1);
    localparam int POLL_W = $clog2(BUSY_POLLS + 1);

    sdw_state_t        state, state_nx;
    sdw_result_t       result_q, result_nx;
    logic              sent;
    logic              multi_q;
    logic [CNT_W-1:0]  blk_left;
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] byte_left;
    logic [RESP_W-1:0] resp_idx;
    logic [POLL_W-1:0] poll_idx;

    logic              sh_go, sh_done, sh_active;
    logic [7:0]        sh_tx, sh_rx;
    logic [15:0]       crc;
    logic              crc_clr, crc_en;

    logic              in_poll, tok_hit, tok_ok, last_try, poll_ready, poll_out;

    assign in_poll    = (state == S_BUSY) || (state == S_STOP_BUSY);
    assign tok_hit    = !sh_rx[4] && sh_rx[0];
    assign tok_ok     = sh_rx[4:0] == SDW_ACCEPTED;
    assign last_try   = resp_idx == RESP_W'(RESP_TRIES - 1);
    assign poll_ready = (poll_idx != '0) && (sh_rx == 8'hFF);
    assign poll_out   = poll_idx == POLL_W'(BUSY_POLLS - 1);

    sdw_spi_shift #(.HALF(HALF)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (sh_go),
        .tx     (sh_tx),
        .miso   (spi_miso),
        .sclk   (spi_sclk),
        .mosi   (spi_mosi),
        .rx     (sh_rx),
        .done   (sh_done),
        .active (sh_active)
    );

    sdw_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (in_data),
        .crc   (crc)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and outcome
    always_comb begin
        state_nx  = state;
        result_nx = result_q;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (blk_count == '0) begin
                        state_nx  = S_DONE;
                        result_nx = SDW_OK;
                    end else begin
                        state_nx = S_FILL;
                    end
                end
            end
            S_FILL:      if (sh_done) state_nx = S_TOKEN;
            S_TOKEN:     if (sh_done) state_nx = (size_q == '0) ? S_CRC_HI : S_DATA;
            S_DATA:      if (sh_done && byte_left == SIZE_W'(1)) state_nx = S_CRC_HI;
            S_CRC_HI:    if (sh_done) state_nx = S_CRC_LO;
            S_CRC_LO:    if (sh_done) state_nx = S_RESP;
            S_RESP: begin
                if (sh_done && (tok_hit || last_try)) begin
                    if (tok_ok) begin
                        state_nx = S_BUSY;
                    end else begin
                        state_nx  = S_DONE;
                        result_nx = SDW_REJECT;
                    end
                end
            end
            S_BUSY: begin
                if (sh_done) begin
                    if (poll_ready) begin
                        if (blk_left == CNT_W'(1)) begin
                            if (multi_q) begin
                                state_nx = S_STOP_FILL;
                            end else begin
                                state_nx  = S_DONE;
                                result_nx = SDW_OK;
                            end
                        end else begin
                            state_nx = S_FILL;
                        end
                    end else if (poll_out) begin
                        state_nx  = S_DONE;
                        result_nx = SDW_TIMEOUT;
                    end
                end
            end
            S_STOP_FILL: if (sh_done) state_nx = S_STOP_TOK;
            S_STOP_TOK:  if (sh_done) state_nx = S_STOP_BUSY;
            S_STOP_BUSY: begin
                if (sh_done) begin
                    if (poll_ready) begin
                        state_nx  = S_DONE;
                        result_nx = SDW_OK;
                    end else if (poll_out) begin
                        state_nx  = S_DONE;
                        result_nx = SDW_TIMEOUT;
                    end
                end
            end
            S_DONE:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // Outputs and byte issue
    always_comb begin
        sh_go    = 1'b0;
        sh_tx    = SDW_IDLE_BYTE;
        in_ready = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        busy     = state != S_IDLE;
        done     = state == S_DONE;
        unique case (state)
            S_FILL: begin
                sh_go   = !sent;
                crc_clr = 1'b1;
            end
            S_TOKEN: begin
                sh_go = !sent;
                sh_tx = multi_q ? SDW_TOK_MULTI : SDW_TOK_ONE;
            end
            S_DATA: begin
                in_ready = !sent;
                sh_go    = !sent && in_valid;
                crc_en   = !sent && in_valid;
                sh_tx    = in_data;
            end
            S_CRC_HI: begin
                sh_go = !sent;
                sh_tx = crc[15:8];
            end
            S_CRC_LO: begin
                sh_go = !sent;
                sh_tx = crc[7:0];
            end
            S_STOP_TOK: begin
                sh_go = !sent;
                sh_tx = SDW_TOK_STOP;
            end
            S_RESP, S_BUSY, S_STOP_FILL, S_STOP_BUSY: begin
                sh_go = !sent;
            end
            default: begin
                sh_go = 1'b0;
            end
        endcase
    end

    assign result = result_q;

    // Counters and latched run settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent      <= 1'b0;
            multi_q   <= 1'b0;
            blk_left  <= '0;
            size_q    <= '0;
            byte_left <= '0;
            resp_idx  <= '0;
            poll_idx  <= '0;
            result_q  <= SDW_OK;
        end else begin
            result_q <= result_nx;
            if (sh_go) begin
                sent <= 1'b1;
            end else if (sh_done) begin
                sent <= 1'b0;
            end
            if (state == S_IDLE && start) begin
                blk_left <= blk_count;
                size_q   <= blk_size;
                multi_q  <= multi;
            end
            if (state == S_TOKEN) begin
                byte_left <= size_q;
            end else if (state == S_DATA && sh_done) begin
                byte_left <= byte_left - SIZE_W'(1);
            end
            resp_idx <= (state == S_RESP) ? resp_idx + RESP_W'(sh_done) : '0;
            poll_idx <= in_poll ? poll_idx + POLL_W'(sh_done) : '0;
            if (state == S_BUSY && sh_done && poll_ready) begin
                blk_left <= blk_left - CNT_W'(1);
            end
        end
    end

    assert_ready_only_idle_shifter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !sh_active);

    assert_stall_no_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(spi_sclk));

    assert_reject_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd1) |-> resp_idx != '0);

    assert_timeout_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd2) |-> poll_idx == POLL_W'(BUSY_POLLS));

    assert_stop_after_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STOP_TOK) |-> blk_left == '0);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_idle_lines_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_mosi && !spi_sclk && !in_ready);

endmodule

// File: tb/sd_blkwr_engine_tb.sv
module sd_blkwr_engine_tb;
    localparam int CNT_W  = 8;
    localparam int SIZE_W = 10;
    localparam int HALF   = 2;
    localparam int TRIES  = 8;
    localparam int POLLS  = 64;
    localparam int LOGN   = 1024;
    localparam int LIMIT  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              multi = 1'b0;
    logic [CNT_W-1:0]  blk_count = '0;
    logic [SIZE_W-1:0] blk_size = '0;
    logic [7:0]        in_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              spi_sclk, spi_mosi, spi_miso;
    logic              busy, done;
    logic [1:0]        result;

    always #5 clk = ~clk;

    sd_blkwr_engine #(
        .CNT_W(CNT_W), .SIZE_W(SIZE_W), .HALF(HALF),
        .RESP_TRIES(TRIES), .BUSY_POLLS(POLLS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .multi(multi),
        .blk_count(blk_count), .blk_size(blk_size),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .busy(busy), .done(done), .result(result)
    );

    // Card model: logs MOSI bytes, serves a scripted MISO byte per byte slot.
    logic [7:0] scr  [0:LOGN-1];
    logic [7:0] logb [0:LOGN-1];
    int         nbytes = 0;
    int         bitcnt = 0;
    int         total_bits = 0;
    logic [7:0] rsh = '0;

    assign spi_miso = scr[nbytes % LOGN][7 - bitcnt];

    always @(posedge spi_sclk) begin
        rsh = {rsh[6:0], spi_mosi};
        bitcnt = bitcnt + 1;
        total_bits = total_bits + 1;
        if (bitcnt == 8) begin
            logb[nbytes % LOGN] = rsh;
            nbytes = nbytes + 1;
            bitcnt = 0;
        end
    end

    int tests = 0;
    int fails = 0;

    // Scenario plan
    int         cdelay [0:7];
    logic [7:0] ctok   [0:7];
    int         cbusy  [0:7];
    logic [7:0] cfirst [0:7];
    int         stop_busy;
    logic [7:0] expb [0:LOGN-1];
    int         exp_n;
    logic [7:0] feed [0:LOGN-1];
    int         feed_n;
    logic [1:0] exp_res;
    int         base;
    bit         abort_run;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int k = 7; k >= 0; k--) begin
            fb = r[15] ^ d[k];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic logic [7:0] dval(input int b, input int i);
        return 8'(8'h3C ^ (b * 17 + i * 29 + 1));
    endfunction

    task automatic push(input logic [7:0] sent_b, input logic [7:0] card_b);
        expb[exp_n] = sent_b;
        scr[(base + exp_n) % LOGN] = card_b;
        exp_n++;
    endtask

    task automatic busy_plan(input logic [7:0] first, input int zeros, output bit to);
        to = 1'b0;
        if (zeros < 0) begin
            for (int k = 0; k < POLLS; k++) push(8'hFF, 8'h00);
            to = 1'b1;
        end else begin
            push(8'hFF, first);
            for (int k = 0; k < zeros; k++) push(8'hFF, 8'h00);
            push(8'hFF, 8'hFF);
        end
    endtask

    task automatic plan_xfer(input int nb, input int sz, input bit mul);
        logic [15:0] c;
        bit          found;
        bit          to;
        base   = nbytes;
        exp_n  = 0;
        feed_n = 0;
        for (int k = 0; k < 512; k++) scr[(base + k) % LOGN] = 8'hFF;
        for (int b = 0; b < nb; b++) begin
            push(8'hFF, 8'hFF);
            push(mul ? 8'hFC : 8'hFE, 8'hFF);
            c = 16'h0000;
            for (int i = 0; i < sz; i++) begin
                push(dval(b, i), 8'hFF);
                feed[feed_n] = dval(b, i);
                feed_n++;
                c = crc_step(c, dval(b, i));
            end
            push(c[15:8], 8'hFF);
            push(c[7:0], 8'hFF);
            found = 1'b0;
            for (int k = 0; k < TRIES; k++) begin
                if (k == cdelay[b]) begin
                    push(8'hFF, ctok[b]);
                    found = 1'b1;
                    break;
                end
                push(8'hFF, 8'hFF);
            end
            if (!found || ctok[b][4:0] != 5'h05) begin
                exp_res = 2'd1;
                return;
            end
            busy_plan(cfirst[b], cbusy[b], to);
            if (to) begin
                exp_res = 2'd2;
                return;
            end
        end
        if (mul && nb > 0) begin
            push(8'hFF, 8'hFF);
            push(8'hFD, 8'hFF);
            busy_plan(8'hFF, stop_busy, to);
            if (to) begin
                exp_res = 2'd2;
                return;
            end
        end
        exp_res = 2'd0;
    endtask

    task automatic feeder(input int stall_at);
        int t0;
        for (int j = 0; j < feed_n; j++) begin
            if (abort_run) return;
            @(negedge clk);
            in_valid = 1'b0;
            if (j == stall_at) begin
                while (!in_ready && !abort_run) @(negedge clk);
                t0 = total_bits;
                repeat (100) @(negedge clk);
                // R2: no SCLK activity while the next payload byte is missing
                chk(total_bits == t0 && in_ready, "R2", "clock held during stall",
                    total_bits - t0, 0);
            end
            in_data  = feed[j];
            in_valid = 1'b1;
            while (!in_ready && !abort_run) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic restarter(input bit restart);
        if (restart) begin
            repeat (150) @(negedge clk);
            // R10: a second start while busy, with other settings, must change nothing
            chk(busy == 1'b1, "R10", "busy before second start", int'(busy), 1);
            blk_count = CNT_W'(5);
            multi     = 1'b1;
            start     = 1'b1;
            @(negedge clk);
            start     = 1'b0;
        end
    endtask

    task automatic waiter(input string tag);
        int         cyc;
        logic [1:0] r;
        cyc = 0;
        while (!done && cyc < LIMIT) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            chk(1'b0, tag, "watchdog expired waiting for done", cyc, LIMIT);
            abort_run = 1'b1;
            return;
        end
        r = result;
        @(negedge clk);
        // R9: done lasts one cycle, busy drops with it, result holds
        chk(!done && !busy && result == r, "R9", "done pulse and held result",
            {done, busy, result}, {2'b00, r});
    endtask

    task automatic run_xfer(input string tag, input int nb, input int sz,
                            input bit mul, input int stall_at, input bit restart);
        int mism;
        int first_bad;
        plan_xfer(nb, sz, mul);
        abort_run = 1'b0;
        @(negedge clk);
        blk_count = CNT_W'(nb);
        blk_size  = SIZE_W'(sz);
        multi     = mul;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        // R9: busy is high once the run is launched (zero-count runs are already at done)
        if (nb != 0) chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        fork
            feeder(stall_at);
            waiter(tag);
            restarter(restart);
        join
        repeat (80) @(negedge clk);
        chk(result == exp_res, tag, "result code", int'(result), int'(exp_res));
        chk(nbytes - base == exp_n, tag, "byte count on MOSI", nbytes - base, exp_n);
        mism = 0;
        first_bad = -1;
        for (int k = 0; k < exp_n && k < nbytes - base; k++) begin
            if (logb[(base + k) % LOGN] != expb[k]) begin
                mism++;
                if (first_bad < 0) first_bad = k;
            end
        end
        if (first_bad >= 0)
            chk(1'b0, tag, $sformatf("MOSI byte %0d", first_bad),
                int'(logb[(base + first_bad) % LOGN]), int'(expb[first_bad]));
        else
            chk(1'b1, tag, "MOSI stream", 0, 0);
        blk_count = '0;
        multi     = 1'b0;
    endtask

    task automatic cfg_clear();
        for (int b = 0; b < 8; b++) begin
            cdelay[b] = 0;
            ctok[b]   = 8'hE5;
            cbusy[b]  = 1;
            cfirst[b] = 8'h00;
        end
        stop_busy = 1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(spi_sclk == 1'b0, "R12", "sclk at reset", int'(spi_sclk), 0);
        chk(spi_mosi == 1'b1, "R12", "mosi at reset", int'(spi_mosi), 1);
        chk(busy == 1'b0, "R12", "busy at reset", int'(busy), 0);
        chk(done == 1'b0, "R12", "done at reset", int'(done), 0);
        chk(in_ready == 1'b0, "R12", "in_ready at reset", int'(in_ready), 0);
    endtask

    // R1 R3 R4 R6 R10: single block, token after one idle byte, first poll 0xFF ignored
    task automatic t_single();
        cfg_clear();
        cdelay[0] = 1; ctok[0] = 8'hE5; cfirst[0] = 8'hFF; cbusy[0] = 2;
        run_xfer("R1/R3/R4/R6", 1, 4, 1'b0, -1, 1'b1);
    endtask

    // R1 R2 R8: three-block multi run with a payload stall in block two
    task automatic t_multi();
        cfg_clear();
        cdelay[0] = 0; ctok[0] = 8'hE5; cfirst[0] = 8'h00; cbusy[0] = 0;
        cdelay[1] = 2; ctok[1] = 8'h25; cfirst[1] = 8'hFF; cbusy[1] = 3;
        cdelay[2] = 0; ctok[2] = 8'h05; cfirst[2] = 8'hFF; cbusy[2] = 1;
        stop_busy = 2;
        run_xfer("R1/R2/R8", 3, 3, 1'b1, 4, 1'b0);
    endtask

    // R5: first block rejected (low bits 0x0B), no second block, no stop token
    task automatic t_reject();
        cfg_clear();
        cdelay[0] = 0; ctok[0] = 8'h0B;
        run_xfer("R5", 2, 2, 1'b1, -1, 1'b0);
    endtask

    // R4 R5: no response token within eight reads
    task automatic t_noresp();
        cfg_clear();
        cdelay[0] = TRIES;
        run_xfer("R4/R5", 1, 2, 1'b0, -1, 1'b0);
    endtask

    // R7: card stays busy after the second block
    task automatic t_timeout();
        cfg_clear();
        cbusy[0] = 1;
        cbusy[1] = -1;
        run_xfer("R7", 2, 2, 1'b0, -1, 1'b0);
    endtask

    // R7 R8: busy never ends after the stop token
    task automatic t_stop_timeout();
        cfg_clear();
        stop_busy = -1;
        run_xfer("R7/R8", 1, 1, 1'b1, -1, 1'b0);
    endtask

    // R11: zero blocks
    task automatic t_zero();
        cfg_clear();
        run_xfer("R11", 0, 4, 1'b1, -1, 1'b0);
    endtask

    initial begin
        for (int k = 0; k < LOGN; k++) begin
            scr[k]  = 8'hFF;
            logb[k] = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_reject();
        t_noresp();
        t_timeout();
        t_stop_timeout();
        t_zero();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule